// File: doc/BRIEF.md
# DRAM Clock Rate Change Sequencer

This block sits on the controller side of a DDR3 memory interface and runs the whole procedure needed to move the device onto a new input clock rate. When asked, it parks the device in one of the two low-power states where the clock may legally change, either precharge power-down or self refresh. It then waits out the entry guard and asks an external clock generator to switch. Once the generator reports a stable clock, the block waits out the exit guard, wakes the device, and resets the DLL with a mode-register command. It may follow that with up to three more mode-register writes for the new rate. It then keeps termination off until the DLL lock time has passed, and only then reports completion.

All four waits share one down-counter, and each wait loads its own programmable length. Commands leave the block as one-cycle strobes that carry a 3-bit opcode and a data field. A separate unit outside the block turns these into pin encodings. A request is accepted only when the device has all banks precharged. Otherwise the request is refused with an error pulse. While a change is in progress, further requests have no effect.

Top module: `freq_change_seq`

## Requirements
- R1: A `req` sampled high while idle with `dev_precharged` high is accepted: `busy` is high from the next cycle and stays high until the cycle `done` is high, when it falls.
- R2: From acceptance until `done`, `odt` is low whatever `odt_req` is. When idle, `odt` follows `odt_req` with one cycle of delay.
- R3: `clk_sw_req` rises exactly `t_cksre`+1 cycles after `cke` falls. It stays high until `clk_stable` is sampled high, and it falls at that same edge.
- R4: `cke` falls together with the entry command, one cycle after acceptance. It stays low, with no intermediate rise, until the exit command.
- R5: The exit command (opcode 3) and the rise of `cke` come exactly `t_cksrx`+1 cycles after the edge at which `clk_stable` was sampled.
- R6: The DLL-reset command (opcode 4, data 0) comes exactly `t_xp`+1 cycles after the exit command.
- R7: Immediately after the DLL reset, `mrw_cnt` (0 to 3) mode-write commands (opcode 5) follow on consecutive cycles. Write i carries `mrw_list[i*16 +: 16]`.
- R8: `done` is a one-cycle pulse exactly `t_dll`+1 cycles after the last mode-register command, whether that is the DLL reset or the final extra write.
- R9: The entry command is opcode 2 (self refresh entry) when `mode_sr` is 1, and opcode 1 (power-down entry) when it is 0. A sequence issues no other commands than those named in R5 to R7, and `cmd_op` is 0 whenever `cmd_vld` is low.
- R10: A `req` sampled while idle with `dev_precharged` low gives a one-cycle `err` pulse on the next cycle. It issues no command, leaves `cke` high and leaves `busy` low.
- R11: A `req` sampled while `busy` is high is ignored: no error, no extra command, and exactly one `done`.
- R12: After reset: `cke` high, `odt` low, `clk_sw_req` low, `busy`, `done`, `err` and `cmd_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a rate change |
| mode_sr | input | 1 | 1: self refresh path, 0: precharge power-down path |
| dev_precharged | input | 1 | Device has all banks precharged and may enter low power |
| odt_req | input | 1 | Termination request from normal traffic |
| t_cksre | input | 8 | Entry guard length |
| t_cksrx | input | 8 | Exit guard length after clock stable |
| t_xp | input | 8 | Wait from exit to DLL reset |
| t_dll | input | 8 | DLL lock wait |
| mrw_cnt | input | 2 | Number of extra mode writes (0 to 3) |
| mrw_list | input | 48 | Extra mode-write data, entry i at bits i*16 +: 16 |
| clk_stable | input | 1 | Generator reports new clock stable |
| clk_sw_req | output | 1 | Ask generator to switch the clock |
| cke | output | 1 | Clock enable to device |
| odt | output | 1 | Termination enable to device |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Opcode: 1 PD entry, 2 SR entry, 3 exit, 4 DLL reset, 5 mode write |
| cmd_data | output | 16 | Mode-write data, 0 otherwise |
| busy | output | 1 | Change in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
Every output is registered, so each result is due at a fixed distance after its trigger. `busy` follows `req` after one edge, and the entry strobe follows one edge after that. `clk_sw_req` comes `t_cksre`+1 edges after the `cke` fall. The exit strobe comes `t_cksrx`+1 edges after `clk_stable` is sampled, the DLL reset `t_xp`+1 edges after exit, and `done` `t_dll`+1 edges after the last mode command. The bench drives and samples on the falling edge and keeps a cycle count that advances on the rising edge. A monitor stamps each port event with that count, and the checks compare differences of the stamps with the exact offsets, including zero-length waits.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ODT_OFF, ST_WAIT_SRE, ST_SWITCH,
        ST_WAIT_SRX, ST_WAIT_XP, ST_MRW, ST_WAIT_DLL
    } fcs_state_e;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_PDE     = 3'd1,
        OP_SRE     = 3'd2,
        OP_EXIT    = 3'd3,
        OP_DLL_RST = 3'd4,
        OP_MRW     = 3'd5
    } fcs_op_e;
endpackage

// File: rtl/fcs_wait_timer.sv
module fcs_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R5: an expired wait stays expired until the next load
    assert_hold_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/fcs_mrw_pick.sv
module fcs_mrw_pick #(
    parameter int DW = 16,
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N*DW-1:0] list_i,
    input  logic [IW-1:0]   idx_i,
    output logic [DW-1:0]   data_o
);
    logic [DW-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign ent[g] = list_i[g*DW +: DW];
    end

    always_comb begin
        data_o = '0;
        for (int k = 0; k < N; k++)
            if (idx_i == IW'(k)) data_o = ent[k];
    end
endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
    import fcs_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MRW_W   = 16,
    parameter int MRW_MAX = 3,
    localparam int IDX_W  = $clog2(MRW_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     mode_sr,
    input  logic                     dev_precharged,
    input  logic                     odt_req,
    input  logic [CNT_W-1:0]         t_cksre,
    input  logic [CNT_W-1:0]         t_cksrx,
    input  logic [CNT_W-1:0]         t_xp,
    input  logic [CNT_W-1:0]         t_dll,
    input  logic [IDX_W-1:0]         mrw_cnt,
    input  logic [MRW_MAX*MRW_W-1:0] mrw_list,
    input  logic                     clk_stable,
    output logic                     clk_sw_req,
    output logic                     cke,
    output logic                     odt,
    output logic                     cmd_vld,
    output logic [2:0]               cmd_op,
    output logic [MRW_W-1:0]         cmd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     err
);
    typedef struct packed {
        fcs_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             cke;
        logic             odt;
        logic             busy;
        logic             done;
        logic             err;
        logic             sw;
        logic             cmd_vld;
        fcs_op_e          op;
        logic [MRW_W-1:0] data;
    } regs_t;

    localparam regs_t RST_VAL = '{st: ST_IDLE, idx: '0, cke: 1'b1, odt: 1'b0,
                                  busy: 1'b0, done: 1'b0, err: 1'b0, sw: 1'b0,
                                  cmd_vld: 1'b0, op: OP_NOP, data: '0};

    regs_t            q, d;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [MRW_W-1:0] pick_data;

    fcs_wait_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    fcs_mrw_pick #(.DW(MRW_W), .N(MRW_MAX), .IW(IDX_W)) u_pick (
        .list_i(mrw_list), .idx_i(q.idx), .data_o(pick_data)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        d.cmd_vld = 1'b0;
        d.op      = OP_NOP;
        d.data    = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (q.st)
            ST_IDLE: begin
                d.odt = odt_req;
                if (req) begin
                    if (dev_precharged) begin
                        d.st   = ST_ODT_OFF;
                        d.busy = 1'b1;
                        d.odt  = 1'b0;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_ODT_OFF: begin
                d.cke     = 1'b0;
                d.cmd_vld = 1'b1;
                d.op      = mode_sr ? OP_SRE : OP_PDE;
                tmr_load  = 1'b1;
                tmr_val   = t_cksre;
                d.st      = ST_WAIT_SRE;
            end
            ST_WAIT_SRE: begin
                if (tmr_zero) begin
                    d.sw = 1'b1;
                    d.st = ST_SWITCH;
                end
            end
            ST_SWITCH: begin
                if (clk_stable) begin
                    d.sw     = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = t_cksrx;
                    d.st     = ST_WAIT_SRX;
                end
            end
            ST_WAIT_SRX: begin
                if (tmr_zero) begin
                    d.cke     = 1'b1;
                    d.cmd_vld = 1'b1;
                    d.op      = OP_EXIT;
                    tmr_load  = 1'b1;
                    tmr_val   = t_xp;
                    d.st      = ST_WAIT_XP;
                end
            end
            ST_WAIT_XP: begin
                if (tmr_zero) begin
                    d.cmd_vld = 1'b1;
                    d.op      = OP_DLL_RST;
                    d.idx     = '0;
                    if (mrw_cnt == '0) begin
                        tmr_load = 1'b1;
                        tmr_val  = t_dll;
                        d.st     = ST_WAIT_DLL;
                    end else begin
                        d.st = ST_MRW;
                    end
                end
            end
            ST_MRW: begin
                d.cmd_vld = 1'b1;
                d.op      = OP_MRW;
                d.data    = pick_data;
                if (q.idx + 1'b1 == mrw_cnt) begin
                    tmr_load = 1'b1;
                    tmr_val  = t_dll;
                    d.st     = ST_WAIT_DLL;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_WAIT_DLL: begin
                if (tmr_zero) begin
                    d.done = 1'b1;
                    d.busy = 1'b0;
                    d.st   = ST_IDLE;
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end

    assign clk_sw_req = q.sw;
    assign cke        = q.cke;
    assign odt        = q.odt;
    assign cmd_vld    = q.cmd_vld;
    assign cmd_op     = q.op;
    assign cmd_data   = q.data;
    assign busy       = q.busy;
    assign done       = q.done;
    assign err        = q.err;

    // R2: termination is off for the whole sequence
    assert_odt_off_busy_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !odt);
    // R4: clock enable low whenever the clock may be switching
    assert_cke_low_switch_R4: assert property (@(posedge clk) disable iff (rst)
        clk_sw_req |-> !cke);
    // R3: switch request held until the generator reports stable
    assert_sw_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_sw_req && !clk_stable) |=> clk_sw_req);
    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: a refusal never coincides with activity
    assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !cmd_vld));
    // R11: requests while busy raise no error
    assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> !err);
endmodule

// File: tb/freq_change_seq_bench.sv
`timescale 1ns/1ps
module freq_change_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, mode_sr = 1'b0, dev_precharged = 1'b1, odt_req = 1'b0;
    logic [7:0]  t_cksre = '0, t_cksrx = '0, t_xp = '0, t_dll = '0;
    logic [1:0]  mrw_cnt = '0;
    logic [47:0] mrw_list = {16'hC003, 16'hB002, 16'hA001};
    logic        clk_stable = 1'b0;
    logic        clk_sw_req, cke, odt, cmd_vld, busy, done, err;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_data;

    freq_change_seq u_freq_change_seq (
        .clk(clk), .rst(rst), .req(req), .mode_sr(mode_sr),
        .dev_precharged(dev_precharged), .odt_req(odt_req),
        .t_cksre(t_cksre), .t_cksrx(t_cksrx), .t_xp(t_xp), .t_dll(t_dll),
        .mrw_cnt(mrw_cnt), .mrw_list(mrw_list), .clk_stable(clk_stable),
        .clk_sw_req(clk_sw_req), .cke(cke), .odt(odt), .cmd_vld(cmd_vld),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // event monitor, sampled on the falling edge
    int t_cke_fall, t_cke_rise, t_sw_rise, t_sw_fall, t_busy_rise, t_busy_fall, t_done;
    int n_cke_rise, n_done, n_err, n_cmd, odt_viol, cke_viol, nop_viol;
    int op_log [8];
    int dat_log [8];
    int cyc_log [8];
    logic cke_p = 1'b1, sw_p = 1'b0, busy_p = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cke_p && !cke) t_cke_fall = cyc;
            if (!cke_p && cke) begin t_cke_rise = cyc; n_cke_rise++; end
            if (!sw_p && clk_sw_req) t_sw_rise = cyc;
            if (sw_p && !clk_sw_req) t_sw_fall = cyc;
            if (!busy_p && busy) t_busy_rise = cyc;
            if (busy_p && !busy) t_busy_fall = cyc;
            if (done) begin n_done++; t_done = cyc; end
            if (err) n_err++;
            if (busy && odt) odt_viol++;
            if (clk_sw_req && cke) cke_viol++;
            if (!cmd_vld && cmd_op != 3'd0) nop_viol++;
            if (cmd_vld) begin
                if (n_cmd < 8) begin
                    op_log[n_cmd]  = int'(cmd_op);
                    dat_log[n_cmd] = int'(cmd_data);
                    cyc_log[n_cmd] = cyc;
                end
                n_cmd++;
            end
        end
        cke_p  = cke;
        sw_p   = clk_sw_req;
        busy_p = busy;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_cke_rise = 0; n_done = 0; n_err = 0; n_cmd = 0;
        odt_viol = 0; cke_viol = 0; nop_viol = 0;
    endtask

    task automatic test_reset();
        chk(cke == 1'b1, "R12 cke after reset", int'(cke), 1);
        chk(odt == 1'b0, "R12 odt after reset", int'(odt), 0);
        chk(clk_sw_req == 1'b0, "R12 clk_sw_req after reset", int'(clk_sw_req), 0);
        chk({busy, done, err, cmd_vld} == 4'b0, "R12 status after reset",
            int'({busy, done, err, cmd_vld}), 0);
    endtask

    task automatic run_seq(input bit sr, input int sre, input int srx, input int xp,
                           input int dll, input int mc, input int stab_dly, input bit poke);
        int e;
        clear_log();
        mode_sr = sr; t_cksre = 8'(sre); t_cksrx = 8'(srx); t_xp = 8'(xp); t_dll = 8'(dll);
        mrw_cnt = 2'(mc); odt_req = 1'b1; dev_precharged = 1'b1;
        @(negedge clk);
        chk(odt == 1'b1, "R2 odt follows request when idle", int'(odt), 1);
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        chk(odt == 1'b0, "R2 odt low at accept", int'(odt), 0);
        @(negedge clk);
        e = sr ? 2 : 1;
        chk(cmd_vld && int'(cmd_op) == e, "R9 entry opcode", int'(cmd_op), e);
        chk(cke == 1'b0, "R4 cke falls with entry", int'(cke), 0);
        for (int i = 0; i < 400 && !clk_sw_req; i++) @(negedge clk);
        if (poke) begin req = 1'b1; @(negedge clk); req = 1'b0; end
        repeat (stab_dly) @(negedge clk);
        clk_stable = 1'b1;
        for (int i = 0; i < 400 && clk_sw_req; i++) @(negedge clk);
        clk_stable = 1'b0;
        for (int i = 0; i < 1200 && n_done == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(t_sw_rise - t_cke_fall == sre + 1, "R3 entry guard", t_sw_rise - t_cke_fall, sre + 1);
        chk(t_cke_rise - t_sw_fall == srx + 1, "R5 exit guard", t_cke_rise - t_sw_fall, srx + 1);
        chk(n_cke_rise == 1 && cke_viol == 0, "R4 cke held low", n_cke_rise, 1);
        chk(n_cmd == 3 + mc, "R9 command count", n_cmd, 3 + mc);
        chk(op_log[1] == 3 && cyc_log[1] == t_cke_rise, "R5 exit command", op_log[1], 3);
        chk(op_log[2] == 4 && dat_log[2] == 0, "R6 DLL reset opcode", op_log[2], 4);
        chk(cyc_log[2] - cyc_log[1] == xp + 1, "R6 exit to DLL reset",
            cyc_log[2] - cyc_log[1], xp + 1);
        for (int i = 0; i < mc; i++) begin
            chk(op_log[3+i] == 5 && cyc_log[3+i] == cyc_log[2] + 1 + i,
                "R7 mode write slot", op_log[3+i], 5);
            chk(dat_log[3+i] == 'hA001 + 'h1001 * i, "R7 mode write data",
                dat_log[3+i], 'hA001 + 'h1001 * i);
        end
        chk(t_done - cyc_log[2+mc] == dll + 1, "R8 DLL lock wait",
            t_done - cyc_log[2+mc], dll + 1);
        chk(n_done == 1, "R8 R11 single done pulse", n_done, 1);
        chk(t_busy_fall == t_done && t_busy_rise == cyc_log[0] - 1, "R1 busy window",
            t_busy_fall, t_done);
        chk(odt_viol == 0 && odt == 1'b1, "R2 odt off while busy, restored after", odt_viol, 0);
        chk(n_err == 0, "R11 no error during sequence", n_err, 0);
        chk(nop_viol == 0, "R9 opcode zero without strobe", nop_viol, 0);
        odt_req = 1'b0;
    endtask

    task automatic test_refuse();
        clear_log();
        dev_precharged = 1'b0;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk(err == 1'b1, "R10 err pulse", int'(err), 1);
        chk(busy == 1'b0 && cke == 1'b1, "R10 no start", int'(busy), 0);
        @(negedge clk);
        chk(err == 1'b0, "R10 err one cycle", int'(err), 0);
        repeat (3) @(negedge clk);
        chk(n_cmd == 0 && busy == 1'b0 && cke == 1'b1, "R10 no command issued", n_cmd, 0);
        dev_precharged = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_seq(1'b0, 3, 2, 4, 6, 0, 3, 1'b0);
        run_seq(1'b1, 0, 0, 0, 0, 3, 0, 1'b0);
        run_seq(1'b0, 5, 7, 1, 9, 2, 5, 1'b0);
        run_seq(1'b1, 2, 3, 2, 4, 1, 2, 1'b1);
        test_refuse();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule